// File: doc/BRIEF.md
# Maskable Interrupt Controller Register File

This block gathers a set of active-high interrupt request lines into a sticky status register. Each status bit stays set until software clears it. A per-line enable mask decides which captured bits can reach a single interrupt request output. The mask only gates reporting. A line that is masked is still captured, and it raises the output as soon as it is enabled again. The only way to clear a status bit is an explicit acknowledge write.

Software reaches four registers over a simple register bus made of a 2-bit select, a write strobe, write data and registered read data. The select codes are: 0 status (read-only), 1 enable (read/write), 2 pending (read-only, the AND of status and enable), 3 acknowledge (write-one-to-clear, reads zero). A build parameter can remove the pending view. The data bus may be wider than the number of interrupt lines, and bits at or above that count are not implemented.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After a synchronous active-high reset, status, enable, irq_out and rd_data are all zero.
- R2: A status bit is set at every clock edge where its input line is high, whatever the enable bit holds, and it stays set until it is acknowledged.
- R3: A write to select 3 clears each status bit whose write-data bit is 1 and leaves the others alone. If the input line is high in the same cycle, the set wins.
- R4: A write to select 1 loads the enable mask from write-data bits below NUM_IRQ. Reading select 1 returns the mask. Write-data bits at or above NUM_IRQ have no effect.
- R5: Reading select 2 returns the bitwise AND of status and enable.
- R6: With HAS_PEND = 0, reading select 2 returns zero.
- R7: irq_out is the OR of all pending bits, registered one cycle. Enabling a bit that is still set raises irq_out one cycle after the enable write, with no new input edge.
- R8: Writes to select 0 and select 2 are ignored. Select 3 reads zero. Read-data bits at or above NUM_IRQ are always zero.
- R9: rd_data is registered. After a clock edge it holds the register chosen by the select sampled at that edge, with the values that register had before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Level-sensitive interrupt request lines |
| reg_sel | input | 2 | Register select (0 status, 1 enable, 2 pending, 3 acknowledge) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge write to a bit whose input line is high in the same cycle, made while that bit is masked. In that case neither irq_out nor a status read shows anything different from a plain hold. Directed steps build this case on purpose: a bit is captured while its enable is off, it is acknowledged during an active request, and it is then re-enabled to confirm that it survived. Random traffic with sparse request lines and mixed register accesses then hits many more such collisions, and a second instance built without the pending view is compared on the same stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_ENABLE  = 2'd1,
    SEL_PENDING = 2'd2,
    SEL_ACK     = 2'd3
  } intc_sel_e;
endpackage

// File: rtl/intc_capture.sv
module intc_capture #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] ack_mask,
  output logic [NUM_IRQ-1:0] status
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            status[i] <= 1'b0;
      else if (irq_in[i]) status[i] <= 1'b1;
      else if (ack_mask[i]) status[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      irq_in[i] |=> status[i]); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
      (status[i] && !ack_mask[i]) |=> status[i]); // R2
  end
endmodule

// File: rtl/intc_mask.sv
module intc_mask #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [NUM_IRQ-1:0] load_val,
  output logic [NUM_IRQ-1:0] enable
);
  always_ff @(posedge clk) begin
    if (rst)       enable <= '0;
    else if (load) enable <= load_val;
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(enable)); // R4
endmodule

// File: rtl/intc_readback.sv
module intc_readback
  import intc_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int DATA_W   = 16,
  parameter bit HAS_PEND = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         sel,
  input  logic [NUM_IRQ-1:0] status,
  input  logic [NUM_IRQ-1:0] enable,
  input  logic [NUM_IRQ-1:0] pending,
  output logic [DATA_W-1:0]  rd_data
);
  logic [NUM_IRQ-1:0] pend_view;
  logic [NUM_IRQ-1:0] pick;
  logic [DATA_W-1:0]  wide;

  if (HAS_PEND) begin : g_pend
    assign pend_view = pending;
  end else begin : g_nopend
    assign pend_view = '0;
    AST_NO_PEND: assert property (@(posedge clk) disable iff (rst)
      (sel == SEL_PENDING) |=> (rd_data == '0)); // R6
  end

  always_comb begin
    unique case (intc_sel_e'(sel))
      SEL_STATUS:  pick = status;
      SEL_ENABLE:  pick = enable;
      SEL_PENDING: pick = pend_view;
      default:     pick = '0;
    endcase
    wide = '0;
    wide[NUM_IRQ-1:0] = pick;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= wide;
  end

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_ACK) |=> (rd_data == '0)); // R8
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int DATA_W   = 16,
  parameter bit HAS_PEND = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [1:0]         reg_sel,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq_out
);
  logic               en_load;
  logic [NUM_IRQ-1:0] ack_mask;
  logic [NUM_IRQ-1:0] status;
  logic [NUM_IRQ-1:0] enable;
  logic [NUM_IRQ-1:0] pending;
  logic               unused_wdata;

  assign unused_wdata = &{1'b0, wr_data};
  assign en_load  = wr_en && (reg_sel == SEL_ENABLE);
  assign ack_mask = (wr_en && reg_sel == SEL_ACK) ? wr_data[NUM_IRQ-1:0] : '0;
  assign pending  = status & enable;

  intc_capture #(.NUM_IRQ(NUM_IRQ)) u_capture (
    .clk(clk), .rst(rst), .irq_in(irq_in), .ack_mask(ack_mask), .status(status)
  );

  intc_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .clk(clk), .rst(rst), .load(en_load), .load_val(wr_data[NUM_IRQ-1:0]),
    .enable(enable)
  );

  intc_readback #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .HAS_PEND(HAS_PEND)) u_rb (
    .clk(clk), .rst(rst), .sel(reg_sel), .status(status), .enable(enable),
    .pending(pending), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |pending;
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
    (|(status & enable)) |=> irq_out); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(status & enable)) |=> !irq_out); // R7
  AST_MASKED_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (irq_in != '0) |=> ((status & $past(irq_in)) == $past(irq_in))); // R2
endmodule

// File: tb/irq_mask_ctrl_test.sv
`timescale 1ns/1ps
module irq_mask_ctrl_test;
  localparam int N = 8;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] irq_in;
  logic [1:0]   reg_sel;
  logic         wr_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data, rd_data_np;
  logic         irq_out, irq_out_np;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [N-1:0] m_st, m_en;

  always #2.5 clk = ~clk;

  irq_mask_ctrl #(.NUM_IRQ(N), .DATA_W(W), .HAS_PEND(1'b1)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out));

  irq_mask_ctrl #(.NUM_IRQ(N), .DATA_W(W), .HAS_PEND(1'b0)) uut_np (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data_np), .irq_out(irq_out_np));

  function automatic logic [W-1:0] exp_read(logic [1:0] s, logic [N-1:0] st,
                                            logic [N-1:0] en, bit pend);
    logic [W-1:0] r = '0;
    case (s)
      2'd0: r[N-1:0] = st;
      2'd1: r[N-1:0] = en;
      2'd2: r[N-1:0] = pend ? (st & en) : '0;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string sel_tag(logic [1:0] s);
    case (s)
      2'd0: return "R2";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] irq, logic [1:0] s, bit we,
                      logic [W-1:0] wd, string tag);
    logic [W-1:0] e_rd, e_rd_np;
    logic         e_irq;
    irq_in = irq; reg_sel = s; wr_en = we; wr_data = wd;
    @(posedge clk);
    e_rd    = exp_read(s, m_st, m_en, 1'b1);
    e_rd_np = exp_read(s, m_st, m_en, 1'b0);
    e_irq   = |(m_st & m_en);
    if (we && s == 2'd3) m_st = m_st & ~wd[N-1:0];
    m_st = m_st | irq;
    if (we && s == 2'd1) m_en = wd[N-1:0];
    @(negedge clk);
    check((tag != "") ? tag : sel_tag(s), rd_data, e_rd);
    check((s == 2'd2) ? "R6" : "R9", rd_data_np, e_rd_np);
    check((tag != "") ? tag : "R7", {{(W-1){1'b0}}, irq_out}, {{(W-1){1'b0}}, e_irq});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; irq_in = '0; reg_sel = '0; wr_en = 0; wr_data = '0;
    m_st = '0; m_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", rd_data, '0);
    check("R1", {{(W-1){1'b0}}, irq_out}, '0);
    rst = 1'b0;
    step('0, 2'd0, 0, '0, "R1");
    step('0, 2'd1, 0, '0, "R1");
    // R2: masked capture, no output
    step(8'h04, 2'd0, 0, '0, "R2");
    step('0, 2'd0, 0, '0, "R2");
    step('0, 2'd2, 0, '0, "R5");
    // R8: writes to status and pending are ignored
    step('0, 2'd0, 1, 16'hFFFF, "R8");
    step('0, 2'd2, 1, 16'hFFFF, "R8");
    step('0, 2'd0, 0, '0, "R8");
    // R3: acknowledge while the line is high keeps the bit
    step(8'h04, 2'd3, 1, 16'h0004, "R3");
    step('0, 2'd0, 0, '0, "R3");
    // R7: re-enable with the bit still set raises irq_out
    step('0, 2'd1, 1, 16'hFF04, "R7");
    step('0, 2'd1, 0, '0, "R4");
    step('0, 2'd2, 0, '0, "R7");
    // R3: acknowledge clears; zero bits leave others
    step(8'h10, 2'd3, 1, 16'h0004, "R3");
    step('0, 2'd0, 0, '0, "R3");
    step('0, 2'd3, 0, '0, "R8");
    step('0, 2'd3, 1, 16'hFFFF, "R3");
    step('0, 2'd0, 0, '0, "R3");
    // R9: registered read sees pre-edge value
    step(8'h01, 2'd0, 0, '0, "R9");
    step('0, 2'd0, 0, '0, "R9");
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] irq = N'($urandom & $urandom & $urandom);
      logic [1:0]   s   = 2'($urandom);
      bit           we  = ($urandom % 3) == 0;
      logic [W-1:0] wd  = W'($urandom);
      step(irq, s, we, wd, "");
    end
    summary();
  end
endmodule